// File: doc/BRIEF.md
# Unary and Shift Group Unit

This block executes two opcode groups of a small 32-bit core in which the middle field of the operand-addressing byte chooses the operation rather than naming a second register. Opcode 0xF7 gives bitwise complement, two's-complement negation and an unsigned widening multiply with the accumulator. Opcode 0xD3 shifts the addressed register left, right with zero fill or right with sign fill, by a count read from the count register. Only the register-direct form is accepted.

The unit sits next to the core's eight-entry register file. It drives the read address of the addressed register from the operand byte. It takes that register's value, the accumulator (index 0) and the count register (index 1) as read data. One clock after an accepted operation it returns up to two single-cycle write strobes. It also keeps the sign, zero and overflow flags in its own registers. Operations the unit does not support raise a one-cycle error pulse and change nothing.

Top module: `unary_shift_unit`

## Requirements
- R1: While reset is asserted, and until the first operation after its release, every write enable, the error pulse and all three flags are 0.
- R2: Opcode 0xF7 with operand byte bits 7:6 = 2'b11 and bits 5:3 = 2 complements the register named by bits 2:0. The result is written back to that register, SF = result bit 31, ZF = (result == 0) and OF = 0.
- R3: Opcode 0xF7 with subop 3 writes the two's-complement negation to the addressed register, with SF = bit 31, ZF = (result == 0) and OF = 0, whenever the operand is not 0x80000000.
- R4: Negating 0x80000000 issues no write and sets SF = 1, ZF = 0 and OF = 1.
- R5: Opcode 0xF7 with subop 4 forms the 64-bit unsigned product of register 0 and the addressed register. The low half goes on write port A to register 0 and the high half goes on write port B to register 2. OF = (high half != 0), and SF and ZF keep their values.
- R6: Opcode 0xD3 with subop 4 shifts the addressed register left and writes it back, with SF = bit 31 and ZF = (result == 0).
- R7: Opcode 0xD3 with subop 5 shifts right with zero fill and writes it back, with ZF = (result == 0) and SF = 0.
- R8: Opcode 0xD3 with subop 7 shifts right with copies of bit 31 and writes it back, with SF = bit 31 and ZF = (result == 0).
- R9: The shift count is bits 4:0 of the count register, and bits 31:5 have no effect.
- R10: With a count of 1, OF = operand bit 31 XOR operand bit 30 for the left and zero-fill shifts, and OF = 0 for the sign-fill shift.
- R11: With any count other than 1, OF keeps its value. A count of 0 still writes back the unchanged operand and updates SF and ZF.
- R12: Under 0xF7 or 0xD3, a subop not listed above, or bits 7:6 other than 2'b11, raises the error pulse for one cycle, issues no write and leaves all flags unchanged.
- R13: A cycle without a valid operation, or a valid operation with any other opcode, issues no write, raises no error and leaves the flags unchanged.
- R14: Results, flags and the error pulse appear on the clock edge that accepts the operation. Write strobes and the error pulse last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | Operand byte: 7:6 addressing form, 5:3 subop, 2:0 register |
| rm_addr | output | 3 | Read address for the addressed register |
| rm_data | input | 32 | Value of the addressed register |
| acc_data | input | 32 | Value of register 0 |
| cnt_data | input | 32 | Value of register 1 |
| wr_a_en | output | 1 | Write strobe, port A |
| wr_a_addr | output | 3 | Destination register, port A |
| wr_a_data | output | 32 | Write data, port A |
| wr_b_en | output | 1 | Write strobe, port B (product high half) |
| wr_b_addr | output | 3 | Destination register, port B (always 2) |
| wr_b_data | output | 32 | Write data, port B |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |
| subop_err | output | 1 | One-cycle pulse for an unsupported operation |

## Verification
On every cycle the assertions check the following:
- an error pulse never comes with a write and never moves a flag;
- a high-half write always comes with the low half aimed at register 0;
- negating the most negative value never writes;
- the sign-fill shift by one always clears OF;
- other shift counts never move OF;
- the zero-fill shift always clears SF;
- an idle cycle produces nothing.

Only the bench scenarios can show that the data values are correct for every operation and count. This covers the 64-bit product halves, the masking of the count to five bits, the shift fill and the flag values after a sequence of operations, because those need a reference computation across many operands.

// File: rtl/usu_pkg.sv
package usu_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int RIDX_W = 3;

  localparam logic [7:0] OPC_UNARY = 8'hF7;
  localparam logic [7:0] OPC_SHIFT = 8'hD3;

  localparam logic [2:0] SEL_NOT = 3'd2;
  localparam logic [2:0] SEL_NEG = 3'd3;
  localparam logic [2:0] SEL_MUL = 3'd4;
  localparam logic [2:0] SEL_SHL = 3'd4;
  localparam logic [2:0] SEL_SHR = 3'd5;
  localparam logic [2:0] SEL_SAR = 3'd7;

  localparam logic [RIDX_W-1:0] IDX_ACC = 3'd0;
  localparam logic [RIDX_W-1:0] IDX_HI  = 3'd2;

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [2:0] {
    OPK_NONE, OPK_NOT, OPK_NEG, OPK_MUL, OPK_SHL, OPK_SHR, OPK_SAR, OPK_BAD
  } op_kind_e;

  typedef struct packed {
    logic [DATA_W-1:0] lo;
    logic [DATA_W-1:0] hi;
    logic              wr_rm;
    logic              wr_pair;
    logic              upd_sz;
    logic              sf;
    logic              zf;
    logic              upd_of;
    logic              of;
  } core_res_t;
endpackage

// File: rtl/usu_decode.sv
module usu_decode
  import usu_pkg::*;
(
  input  logic       op_valid,
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  output op_kind_e   kind
);
  logic       direct;
  logic [2:0] sel;

  assign direct = (modrm[7:6] == 2'b11);
  assign sel    = modrm[5:3];

  always_comb begin
    kind = OPK_NONE;
    if (op_valid) begin
      if (opcode == OPC_UNARY) begin
        case (sel)
          SEL_NOT: kind = OPK_NOT;
          SEL_NEG: kind = OPK_NEG;
          SEL_MUL: kind = OPK_MUL;
          default: kind = OPK_BAD;
        endcase
        if (!direct) kind = OPK_BAD;
      end else if (opcode == OPC_SHIFT) begin
        case (sel)
          SEL_SHL: kind = OPK_SHL;
          SEL_SHR: kind = OPK_SHR;
          SEL_SAR: kind = OPK_SAR;
          default: kind = OPK_BAD;
        endcase
        if (!direct) kind = OPK_BAD;
      end
    end
  end
endmodule

// File: rtl/usu_unary.sv
module usu_unary
  import usu_pkg::*;
(
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] acc,
  output core_res_t         res
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] inv;
  logic [DATA_W-1:0] neg;

  assign prod = {{DATA_W{1'b0}}, acc} * {{DATA_W{1'b0}}, x};
  assign inv  = ~x;
  assign neg  = '0 - x;

  always_comb begin
    res = '0;
    case (kind)
      OPK_NOT: begin
        res.lo     = inv;
        res.wr_rm  = 1'b1;
        res.upd_sz = 1'b1;
        res.sf     = inv[DATA_W-1];
        res.zf     = (inv == '0);
        res.upd_of = 1'b1;
      end
      OPK_NEG: begin
        res.upd_sz = 1'b1;
        res.upd_of = 1'b1;
        if (x == MOST_NEG) begin
          res.lo = x;
          res.sf = 1'b1;
          res.zf = 1'b0;
          res.of = 1'b1;
        end else begin
          res.lo    = neg;
          res.wr_rm = 1'b1;
          res.sf    = neg[DATA_W-1];
          res.zf    = (neg == '0);
        end
      end
      OPK_MUL: begin
        res.lo      = prod[DATA_W-1:0];
        res.hi      = prod[PROD_W-1:DATA_W];
        res.wr_pair = 1'b1;
        res.upd_of  = 1'b1;
        res.of      = |prod[PROD_W-1:DATA_W];
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/usu_shift.sv
module usu_shift
  import usu_pkg::*;
(
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] x,
  input  logic [CNT_W-1:0]  cnt,
  output core_res_t         res
);
  logic              is_left;
  logic              fill;
  logic [DATA_W-1:0] x_rev;
  logic [DATA_W-1:0] out_rev;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] stg [CNT_W+1];

  assign is_left = (kind == OPK_SHL);
  assign fill    = (kind == OPK_SAR) & x[DATA_W-1];

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign x_rev[b]   = x[DATA_W-1-b];
    assign out_rev[b] = stg[CNT_W][DATA_W-1-b];
  end

  assign stg[0] = is_left ? x_rev : x;

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stg[i+1] = cnt[i] ? {{STEP{fill}}, stg[i][DATA_W-1:STEP]} : stg[i];
  end

  assign shifted = is_left ? out_rev : stg[CNT_W];

  always_comb begin
    res = '0;
    if (kind == OPK_SHL || kind == OPK_SHR || kind == OPK_SAR) begin
      res.lo     = shifted;
      res.wr_rm  = 1'b1;
      res.upd_sz = 1'b1;
      res.sf     = (kind == OPK_SHR) ? 1'b0 : shifted[DATA_W-1];
      res.zf     = (shifted == '0);
      res.upd_of = (cnt == CNT_W'(1));
      res.of     = (kind == OPK_SAR) ? 1'b0 : (x[DATA_W-1] ^ x[DATA_W-2]);
    end
  end
endmodule

// File: rtl/unary_shift_unit.sv
module unary_shift_unit
  import usu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  output logic [RIDX_W-1:0] rm_addr,
  input  logic [DATA_W-1:0] rm_data,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [DATA_W-1:0] cnt_data,
  output logic              wr_a_en,
  output logic [RIDX_W-1:0] wr_a_addr,
  output logic [DATA_W-1:0] wr_a_data,
  output logic              wr_b_en,
  output logic [RIDX_W-1:0] wr_b_addr,
  output logic [DATA_W-1:0] wr_b_data,
  output logic              flag_sf,
  output logic              flag_zf,
  output logic              flag_of,
  output logic              subop_err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  op_kind_e  kind;
  core_res_t u_res;
  core_res_t s_res;
  core_res_t sel;
  logic      unused_cnt_hi;

  assign rm_addr       = modrm[RIDX_W-1:0];
  assign unused_cnt_hi = ^cnt_data[DATA_W-1:CNT_W];

  usu_decode u_dec (
    .op_valid (op_valid),
    .opcode   (opcode),
    .modrm    (modrm),
    .kind     (kind)
  );

  usu_unary u_una (
    .kind (kind),
    .x    (rm_data),
    .acc  (acc_data),
    .res  (u_res)
  );

  usu_shift u_shf (
    .kind (kind),
    .x    (rm_data),
    .cnt  (cnt_data[CNT_W-1:0]),
    .res  (s_res)
  );

  // next state
  logic              wa_en_d;
  logic [RIDX_W-1:0] wa_addr_d;
  logic              wb_en_d;
  logic              sz_ce;
  logic              of_ce;
  logic              err_d;

  always_comb begin
    sel       = u_res | s_res;
    wa_en_d   = sel.wr_rm | sel.wr_pair;
    wa_addr_d = sel.wr_pair ? IDX_ACC : modrm[RIDX_W-1:0];
    wb_en_d   = sel.wr_pair;
    sz_ce     = sel.upd_sz;
    of_ce     = sel.upd_of;
    err_d     = (kind == OPK_BAD);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_a_en   <= 1'b0;
      wr_b_en   <= 1'b0;
      subop_err <= 1'b0;
    end else begin
      wr_a_en   <= wa_en_d;
      wr_b_en   <= wb_en_d;
      subop_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_a_addr <= '0;
      wr_a_data <= '0;
    end else if (wa_en_d) begin
      wr_a_addr <= wa_addr_d;
      wr_a_data <= sel.lo;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   wr_b_data <= '0;
    else if (wb_en_d) wr_b_data <= sel.hi;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flag_sf <= 1'b0;
      flag_zf <= 1'b0;
    end else if (sz_ce) begin
      flag_sf <= sel.sf;
      flag_zf <= sel.zf;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  flag_of <= 1'b0;
    else if (of_ce)  flag_of <= sel.of;
  end

  assign wr_b_addr = IDX_HI;

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    subop_err |-> (!wr_a_en && !wr_b_en)); // R12
  AST_ERR_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    subop_err |-> $stable({flag_sf, flag_zf, flag_of})); // R12
  AST_NEG_MIN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == OPK_NEG && rm_data == MOST_NEG) |=> (!wr_a_en && flag_of && flag_sf && !flag_zf)); // R4
  AST_PAIR_DEST: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_b_en |-> (wr_a_en && wr_a_addr == IDX_ACC)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !op_valid |=> (!wr_a_en && !wr_b_en && !subop_err)); // R13
  AST_SAR_ONE_OF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == OPK_SAR && cnt_data[CNT_W-1:0] == CNT_W'(1)) |=> !flag_of); // R10
  AST_OF_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((kind == OPK_SHL || kind == OPK_SHR || kind == OPK_SAR) && cnt_data[CNT_W-1:0] != CNT_W'(1))
    |=> $stable(flag_of)); // R11
  AST_SHR_SF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == OPK_SHR) |=> (!flag_sf && wr_a_en)); // R7
endmodule

// File: tb/unary_shift_unit_test.sv
`timescale 1ns/1ps
module unary_shift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  opcode;
  logic [7:0]  modrm;
  logic [2:0]  rm_addr;
  logic [31:0] rm_data, acc_data, cnt_data;
  logic        wr_a_en, wr_b_en, flag_sf, flag_zf, flag_of, subop_err;
  logic [2:0]  wr_a_addr, wr_b_addr;
  logic [31:0] wr_a_data, wr_b_data;

  logic [31:0] rf [8];
  logic        e_sf, e_zf, e_of;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  assign rm_data  = rf[rm_addr];
  assign acc_data = rf[0];
  assign cnt_data = rf[1];

  unary_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .modrm(modrm),
    .rm_addr(rm_addr), .rm_data(rm_data), .acc_data(acc_data), .cnt_data(cnt_data),
    .wr_a_en(wr_a_en), .wr_a_addr(wr_a_addr), .wr_a_data(wr_a_data),
    .wr_b_en(wr_b_en), .wr_b_addr(wr_b_addr), .wr_b_data(wr_b_data),
    .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of), .subop_err(subop_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [7:0] mrm);
    logic [31:0] x, r, ad, bd;
    logic [63:0] p;
    logic [4:0]  c;
    logic [2:0]  aa;
    bit          ea, eb, ee;
    logic        nsf, nzf, nof;
    string       t, tof;
    x = rf[mrm[2:0]]; c = rf[1][4:0]; aa = mrm[2:0];
    ea = 0; eb = 0; ee = 0; ad = '0; bd = '0; r = '0;
    nsf = e_sf; nzf = e_zf; nof = e_of; t = "R13";
    if (opc == 8'hF7 || opc == 8'hD3) begin
      if (mrm[7:6] != 2'b11) begin ee = 1; t = "R12"; end
      else if (opc == 8'hF7) begin
        case (mrm[5:3])
          3'd2: begin r = ~x; ea = 1; ad = r; nsf = r[31]; nzf = (r == 0); nof = 0; t = "R2"; end
          3'd3: begin
            if (x == 32'h8000_0000) begin nsf = 1; nzf = 0; nof = 1; t = "R4"; end
            else begin r = -x; ea = 1; ad = r; nsf = r[31]; nzf = (r == 0); nof = 0; t = "R3"; end
          end
          3'd4: begin
            p = {32'h0, rf[0]} * {32'h0, x};
            ea = 1; aa = 3'd0; ad = p[31:0]; eb = 1; bd = p[63:32]; nof = |p[63:32]; t = "R5";
          end
          default: begin ee = 1; t = "R12"; end
        endcase
      end else begin
        case (mrm[5:3])
          3'd4: begin r = x << c; t = "R6"; if (c == 1) nof = x[31] ^ x[30]; nsf = r[31]; end
          3'd5: begin r = x >> c; t = "R7"; if (c == 1) nof = x[31] ^ x[30]; nsf = 1'b0; end
          3'd7: begin r = 32'($signed(x) >>> c); t = "R8"; if (c == 1) nof = 1'b0; nsf = r[31]; end
          default: begin ee = 1; t = "R12"; end
        endcase
        if (!ee) begin ea = 1; ad = r; nzf = (r == 0); end
      end
    end
    tof = t;
    if (opc == 8'hD3 && !ee) tof = (c == 1) ? "R10" : "R11";

    @(negedge clk);
    op_valid = 1'b1; opcode = opc; modrm = mrm;
    @(posedge clk); #1;
    chk(subop_err == ee, t, "subop_err", 64'(subop_err), 64'(ee));
    chk(wr_a_en == ea, t, "wr_a_en", 64'(wr_a_en), 64'(ea));
    if (ea) begin
      chk(wr_a_addr == aa, t, "wr_a_addr", 64'(wr_a_addr), 64'(aa));
      chk(wr_a_data == ad, t, "wr_a_data", 64'(wr_a_data), 64'(ad));
    end
    chk(wr_b_en == eb, t, "wr_b_en", 64'(wr_b_en), 64'(eb));
    if (eb) begin
      chk(wr_b_addr == 3'd2, "R5", "wr_b_addr", 64'(wr_b_addr), 64'd2);
      chk(wr_b_data == bd, "R5", "wr_b_data", 64'(wr_b_data), 64'(bd));
    end
    chk(flag_sf == nsf, t, "flag_sf", 64'(flag_sf), 64'(nsf));
    chk(flag_zf == nzf, t, "flag_zf", 64'(flag_zf), 64'(nzf));
    chk(flag_of == nof, tof, "flag_of", 64'(flag_of), 64'(nof));
    if (ea) rf[aa] = ad;
    if (eb) rf[2] = bd;
    e_sf = nsf; e_zf = nzf; e_of = nof;
    @(negedge clk);
    op_valid = 1'b0;
    @(posedge clk); #1;
    chk(!wr_a_en && !wr_b_en && !subop_err, "R14", "strobes after one cycle",
        64'({wr_a_en, wr_b_en, subop_err}), 64'd0);
  endtask

  task automatic chk_reset(input string what);
    chk({wr_a_en, wr_b_en, subop_err, flag_sf, flag_zf, flag_of} == 6'b0, "R1", what,
        64'({wr_a_en, wr_b_en, subop_err, flag_sf, flag_zf, flag_of}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) rf[i] = '0;
    e_sf = 0; e_zf = 0; e_of = 0;
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; modrm = '0;
    repeat (5) @(posedge clk);
    #1 chk_reset("during reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk_reset("after release");

    // R2 complement
    rf[3] = 32'h0F0F_00FF; run_op(8'hF7, 8'hD3);
    // R3 negate, including zero
    rf[3] = 32'd1;         run_op(8'hF7, 8'hDB);
    rf[5] = 32'd0;         run_op(8'hF7, 8'hDD);
    // R4 most negative
    rf[3] = 32'h8000_0000; run_op(8'hF7, 8'hDB);
    // R5 multiply, small, full width, accumulator squared
    rf[0] = 32'd4; rf[1] = 32'd3; run_op(8'hF7, 8'hE1);
    rf[0] = 32'hFFFF_FFFF; rf[6] = 32'hFFFF_FFFF; run_op(8'hF7, 8'hE6);
    rf[0] = 32'h0001_0000; run_op(8'hF7, 8'hE0);
    // R6 R7 R8 R10 count one
    rf[1] = 32'd1;
    rf[3] = 32'd13;        run_op(8'hD3, 8'hE3);
    rf[3] = 32'hFFFF_FFFD; run_op(8'hD3, 8'hFB);
    rf[3] = 32'hFFFF_FFFD; run_op(8'hD3, 8'hEB);
    rf[3] = 32'd27;        run_op(8'hD3, 8'hFB);
    rf[3] = 32'd27;        run_op(8'hD3, 8'hEB);
    rf[3] = 32'h4000_0000; run_op(8'hD3, 8'hE3);
    // R9 upper count bits ignored (33 acts as 1)
    rf[1] = 32'd33; rf[4] = 32'h8000_0001; run_op(8'hD3, 8'hE4);
    // R11 OF held with count 3 and count 0
    rf[1] = 32'd3;  rf[4] = 32'h4000_0000; run_op(8'hD3, 8'hE4);
    rf[1] = 32'hFFFF_FFE0; rf[7] = 32'd0;  run_op(8'hD3, 8'hFF);
    // R12 unsupported subops and memory form
    run_op(8'hF7, 8'hC3);
    run_op(8'hD3, 8'hF3);
    run_op(8'hF7, 8'h13);
    // R13 other opcode
    run_op(8'h01, 8'hD8);

    for (int n = 0; n < 500; n++) begin
      logic [7:0] opc, mrm;
      int sel;
      if (($urandom % 4) == 0) for (int k = 0; k < 8; k++) rf[k] = $urandom;
      if (($urandom % 2) == 0) rf[1] = $urandom % 34;
      if (($urandom % 6) == 0) rf[$urandom % 8] = 32'h8000_0000;
      sel = $urandom % 10;
      opc = (sel < 4) ? 8'hF7 : (sel < 9) ? 8'hD3 : 8'($urandom);
      mrm = 8'($urandom);
      if (($urandom % 8) != 0) mrm[7:6] = 2'b11;
      run_op(opc, mrm);
    end

    report();
    $finish;
  end
endmodule